// File: doc/BRIEF.md
# Diagnostic Threshold Flag Generator

This block watches five monitored quantities of an optical link module: internal temperature, supply voltage, laser bias current, launched optical power and received optical power. It checks each one against four stored limits (an upper and a lower alarm, and an upper and a lower warning). The result is four flag bytes that a management reader can fetch. The limits live in a small byte-addressed bank that is loaded one byte at a time.

A new set of readings arrives with a one-cycle sample strobe. The flags are worked out from that set and latched together. A reader therefore never sees flags that come from two different samples. Until the first strobe, every flag reads as zero and the ready indication stays low.

Temperature is a signed two's-complement value. The other four quantities are unsigned codes. The flag bytes use a fixed layout of two bits per quantity, so that a downstream decoder can map the bits directly.

Top module: `dtf_flag_gen`

## Requirements
- R1: While reset is active, all four flag bytes read 0x00 and `data_ready` reads 0.
- R2: Before the first `smp_valid` strobe, all flag bytes stay 0x00 and `data_ready` stays 0, whatever happens on the sample and threshold inputs. From the cycle after the first strobe, `data_ready` is 1 and stays 1.
- R3: An upper flag (alarm or warning) is 1 exactly when the sampled value is strictly greater than the matching upper limit. A value equal to the limit leaves the flag at 0.
- R4: A lower flag (alarm or warning) is 1 exactly when the sampled value is strictly less than the matching lower limit. A value equal to the limit leaves the flag at 0.
- R5: Temperature limits and temperature samples are compared as signed 16-bit two's complement. Supply, bias, transmit-power and receive-power values are compared as unsigned 16-bit numbers.
- R6: Limit bank layout:
  - Quantity index q (temperature 0, supply 1, bias 2, transmit power 3, receive power 4) owns bytes 8q to 8q+7.
  - Inside those bytes, the limits sit at offsets 0, 2, 4 and 6, in the order upper alarm, lower alarm, upper warning, lower warning.
  - Each limit is stored most significant byte at the even address and least significant byte at the odd address.
  - Writes to addresses 40 to 63 change no limit.
- R7: Alarm byte A holds the pairs in this order:
  - bit 7 temperature upper, bit 6 temperature lower
  - bit 5 supply upper, bit 4 supply lower
  - bit 3 bias upper, bit 2 bias lower
  - bit 1 transmit-power upper, bit 0 transmit-power lower
  
  Alarm byte B holds receive-power upper at bit 7 and receive-power lower at bit 6. Bits 5 to 0 of byte B are always 0.
- R8: Warning bytes A and B use the same bit layout as R7, driven by the warning limits instead of the alarm limits.
- R9: The flag bytes change only on the clock edge that samples `smp_valid` high. All four bytes change together and show the new values from the next cycle on. Changes to the samples or limits without a strobe have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_wr_en | input | 1 | Limit bank byte write enable |
| thr_wr_addr | input | 6 | Limit bank byte address |
| thr_wr_data | input | 8 | Limit bank byte data |
| smp_valid | input | 1 | New sample strobe, one cycle |
| smp_temp | input | 16 | Temperature sample, signed, 1/256 degree steps |
| smp_vcc | input | 16 | Supply sample, unsigned, 100 uV steps |
| smp_bias | input | 16 | Bias current sample, unsigned, 2 uA steps |
| smp_txpwr | input | 16 | Launched power sample, unsigned, 0.1 uW steps |
| smp_rxpwr | input | 16 | Received power sample, unsigned, 0.1 uW steps |
| alarm_flags_a | output | 8 | Alarm byte A |
| alarm_flags_b | output | 8 | Alarm byte B |
| warn_flags_a | output | 8 | Warning byte A |
| warn_flags_b | output | 8 | Warning byte B |
| data_ready | output | 1 | First sample has been evaluated |

## Verification
Some behaviours are checked by assertions on every cycle:
- the flag bytes hold steady between strobes;
- `data_ready` never drops once it is set, and rises after a strobe;
- the flags are zero while `data_ready` is low;
- a comparator never raises both of its flags when its limits are in order.

Other behaviours only the bench scenarios can show:
- the strict-inequality edges at limit, limit minus one and limit plus one;
- signed against unsigned treatment near 0x7FFF and 0x8000;
- the exact bit placement of each quantity;
- the byte ordering of the limit bank, and that writes beyond it are ignored.

The bench shows these by sweeping each quantity across every limit and comparing against its own arithmetic model.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
   localparam int NUM_Q   = 5;   // monitored quantities
   localparam int NUM_LIM = 4;   // limits per quantity
   localparam int LIM_HI_ALM = 0;
   localparam int LIM_LO_ALM = 1;
   localparam int LIM_HI_WRN = 2;
   localparam int LIM_LO_WRN = 3;
   localparam int FLAG_VEC_W = 16; // two flag bytes per severity
endpackage

// File: rtl/dtf_thr_bank.sv
module dtf_thr_bank
   import dtf_pkg::*;
#(
   parameter int VAL_W  = 16,
   parameter int ADDR_W = 6
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         wr_en,
   input  logic [ADDR_W-1:0]                            wr_addr,
   input  logic [7:0]                                   wr_data,
   output logic [NUM_Q-1:0][NUM_LIM-1:0][VAL_W-1:0]     thr_out
);
   localparam int BPV        = VAL_W / 8;
   localparam int BANK_BYTES = NUM_Q * NUM_LIM * BPV;

   if (VAL_W % 8 != 0) begin : g_bad_val_w
      $error("dtf_thr_bank: VAL_W must be a whole number of bytes");
   end
   if ((1 << ADDR_W) < BANK_BYTES) begin : g_bad_addr_w
      $error("dtf_thr_bank: ADDR_W too small for the limit bank");
   end

   logic [7:0] bank_q [BANK_BYTES];

   for (genvar i = 0; i < BANK_BYTES; i++) begin : g_byte
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q[i] <= 8'h00;
         else if (wr_en && (wr_addr == MY_ADDR))
            bank_q[i] <= wr_data;
      end
   end

   // most significant byte at the lowest address of each limit
   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      for (genvar k = 0; k < NUM_LIM; k++) begin : g_k
         for (genvar b = 0; b < BPV; b++) begin : g_b
            assign thr_out[q][k][VAL_W-1-8*b -: 8] = bank_q[(q*NUM_LIM + k)*BPV + b];
         end
      end
   end
endmodule

// File: rtl/dtf_lim_cmp.sv
module dtf_lim_cmp #(
   parameter int VAL_W     = 16,
   parameter bit IS_SIGNED = 1'b0
) (
   input  logic [VAL_W-1:0] value,
   input  logic [VAL_W-1:0] hi_lim,
   input  logic [VAL_W-1:0] lo_lim,
   output logic             above,
   output logic             below
);
   logic lims_ordered;

   if (IS_SIGNED) begin : g_signed
      assign above        = $signed(value)  > $signed(hi_lim);
      assign below        = $signed(value)  < $signed(lo_lim);
      assign lims_ordered = $signed(hi_lim) >= $signed(lo_lim);
   end else begin : g_unsigned
      assign above        = value  > hi_lim;
      assign below        = value  < lo_lim;
      assign lims_ordered = hi_lim >= lo_lim;
   end

   // R3 / R4: with ordered limits a value cannot be both above and below
   always_comb begin
      if (!$isunknown({value, hi_lim, lo_lim}) && lims_ordered)
         a_r3_r4_exclusive : assert (!(above && below));
   end
endmodule

// File: rtl/dtf_flag_pack.sv
module dtf_flag_pack
   import dtf_pkg::*;
(
   input  logic [NUM_Q-1:0]      hi,
   input  logic [NUM_Q-1:0]      lo,
   output logic [FLAG_VEC_W-1:0] packed_flags
);
   localparam int USED = 2 * NUM_Q;

   if (USED > FLAG_VEC_W) begin : g_bad_pack
      $error("dtf_flag_pack: too many quantities for two bytes");
   end

   // quantity q: upper at bit 15-2q, lower at bit 14-2q
   for (genvar q = 0; q < NUM_Q; q++) begin : g_pair
      assign packed_flags[FLAG_VEC_W-1-2*q] = hi[q];
      assign packed_flags[FLAG_VEC_W-2-2*q] = lo[q];
   end
   for (genvar z = 0; z < FLAG_VEC_W - USED; z++) begin : g_zero
      assign packed_flags[z] = 1'b0;
   end
endmodule

// File: rtl/dtf_flag_gen.sv
module dtf_flag_gen
   import dtf_pkg::*;
#(
   parameter int               VAL_W       = 16,
   parameter int               ADDR_W      = 6,
   parameter logic [NUM_Q-1:0] SIGNED_MASK = 5'b00001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thr_wr_en,
   input  logic [ADDR_W-1:0] thr_wr_addr,
   input  logic [7:0]        thr_wr_data,
   input  logic              smp_valid,
   input  logic [VAL_W-1:0]  smp_temp,
   input  logic [VAL_W-1:0]  smp_vcc,
   input  logic [VAL_W-1:0]  smp_bias,
   input  logic [VAL_W-1:0]  smp_txpwr,
   input  logic [VAL_W-1:0]  smp_rxpwr,
   output logic [7:0]        alarm_flags_a,
   output logic [7:0]        alarm_flags_b,
   output logic [7:0]        warn_flags_a,
   output logic [7:0]        warn_flags_b,
   output logic              data_ready
);
   if (VAL_W < 8) begin : g_bad_w
      $error("dtf_flag_gen: VAL_W must be at least 8");
   end

   logic [NUM_Q-1:0][VAL_W-1:0]              smp_vec;
   logic [NUM_Q-1:0][NUM_LIM-1:0][VAL_W-1:0] thr;
   logic [NUM_Q-1:0] alm_hi, alm_lo, wrn_hi, wrn_lo;
   logic [FLAG_VEC_W-1:0] alm_next, wrn_next;
   logic [FLAG_VEC_W-1:0] alm_q, wrn_q;
   logic                  ready_q;

   assign smp_vec[0] = smp_temp;
   assign smp_vec[1] = smp_vcc;
   assign smp_vec[2] = smp_bias;
   assign smp_vec[3] = smp_txpwr;
   assign smp_vec[4] = smp_rxpwr;

   dtf_thr_bank #(.VAL_W(VAL_W), .ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (thr_wr_en),
      .wr_addr (thr_wr_addr),
      .wr_data (thr_wr_data),
      .thr_out (thr)
   );

   for (genvar q = 0; q < NUM_Q; q++) begin : g_cmp
      dtf_lim_cmp #(.VAL_W(VAL_W), .IS_SIGNED(SIGNED_MASK[q])) u_alm (
         .value  (smp_vec[q]),
         .hi_lim (thr[q][LIM_HI_ALM]),
         .lo_lim (thr[q][LIM_LO_ALM]),
         .above  (alm_hi[q]),
         .below  (alm_lo[q])
      );
      dtf_lim_cmp #(.VAL_W(VAL_W), .IS_SIGNED(SIGNED_MASK[q])) u_wrn (
         .value  (smp_vec[q]),
         .hi_lim (thr[q][LIM_HI_WRN]),
         .lo_lim (thr[q][LIM_LO_WRN]),
         .above  (wrn_hi[q]),
         .below  (wrn_lo[q])
      );
   end

   dtf_flag_pack u_pack_alm (.hi(alm_hi), .lo(alm_lo), .packed_flags(alm_next));
   dtf_flag_pack u_pack_wrn (.hi(wrn_hi), .lo(wrn_lo), .packed_flags(wrn_next));

   // all flag bytes latch together on the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_q   <= '0;
         wrn_q   <= '0;
         ready_q <= 1'b0;
      end else if (smp_valid) begin
         alm_q   <= alm_next;
         wrn_q   <= wrn_next;
         ready_q <= 1'b1;
      end
   end

   assign alarm_flags_a = alm_q[15:8];
   assign alarm_flags_b = alm_q[7:0];
   assign warn_flags_a  = wrn_q[15:8];
   assign warn_flags_b  = wrn_q[7:0];
   assign data_ready    = ready_q;

   a_r9_hold_without_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable({alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b}));

   a_r2_ready_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |=> data_ready);

   a_r2_ready_after_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> data_ready);

   a_r2_zero_until_ready : assert property (@(posedge clk) disable iff (!rst_n)
      !data_ready |-> ({alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b} == 32'h0));
endmodule

// File: tb/dtf_flag_gen_test.sv
module dtf_flag_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        thr_wr_en = 1'b0;
   logic [5:0]  thr_wr_addr = '0;
   logic [7:0]  thr_wr_data = '0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_temp = '0, smp_vcc = '0, smp_bias = '0, smp_txpwr = '0, smp_rxpwr = '0;
   logic [7:0]  alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b;
   logic        data_ready;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [15:0] bthr [5][4];
   logic [15:0] bval [5];
   logic [31:0] last_exp;

   always #5 clk = ~clk;

   dtf_flag_gen uut (
      .clk(clk), .rst_n(rst_n),
      .thr_wr_en(thr_wr_en), .thr_wr_addr(thr_wr_addr), .thr_wr_data(thr_wr_data),
      .smp_valid(smp_valid),
      .smp_temp(smp_temp), .smp_vcc(smp_vcc), .smp_bias(smp_bias),
      .smp_txpwr(smp_txpwr), .smp_rxpwr(smp_rxpwr),
      .alarm_flags_a(alarm_flags_a), .alarm_flags_b(alarm_flags_b),
      .warn_flags_a(warn_flags_a), .warn_flags_b(warn_flags_b),
      .data_ready(data_ready)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] flags_now();
      return {alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b};
   endfunction

   function automatic bit gt(input int q, input logic [15:0] v, input logic [15:0] t);
      if (q == 0) return $signed(v) > $signed(t);
      return v > t;
   endfunction

   function automatic bit lt(input int q, input logic [15:0] v, input logic [15:0] t);
      if (q == 0) return $signed(v) < $signed(t);
      return v < t;
   endfunction

   // arithmetic model of R3, R4, R5, R7, R8
   function automatic logic [31:0] model();
      logic [15:0] alm = '0;
      logic [15:0] wrn = '0;
      for (int q = 0; q < 5; q++) begin
         alm[15-2*q] = gt(q, bval[q], bthr[q][0]);
         alm[14-2*q] = lt(q, bval[q], bthr[q][1]);
         wrn[15-2*q] = gt(q, bval[q], bthr[q][2]);
         wrn[14-2*q] = lt(q, bval[q], bthr[q][3]);
      end
      return {alm, wrn};
   endfunction

   task automatic wr_byte(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      thr_wr_en = 1'b1; thr_wr_addr = a; thr_wr_data = d;
      @(negedge clk);
      thr_wr_en = 1'b0;
   endtask

   // R6: quantity q base 8q, limit k at +2k, MSB first
   task automatic wr_lim(input int q, input int k, input logic [15:0] v);
      wr_byte(6'(8*q + 2*k), v[15:8]);
      wr_byte(6'(8*q + 2*k + 1), v[7:0]);
      bthr[q][k] = v;
   endtask

   task automatic drive_vals();
      smp_temp = bval[0]; smp_vcc = bval[1]; smp_bias = bval[2];
      smp_txpwr = bval[3]; smp_rxpwr = bval[4];
   endtask

   task automatic strobe_and_check(input string tag);
      @(negedge clk);
      drive_vals();
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      last_exp = model();
      chk(tag, flags_now(), last_exp);
   endtask

   task automatic set_mid();
      bval[0] = 16'h0100; bval[1] = 16'd33000; bval[2] = 16'd20000;
      bval[3] = 16'd2000; bval[4] = 16'd2000;
   endtask

   initial begin
      logic [15:0] init_thr [5][4];
      init_thr[0] = '{16'h1E00, 16'hF600, 16'h1400, 16'hFB00};
      init_thr[1] = '{16'd36000, 16'd30000, 16'd35000, 16'd31000};
      init_thr[2] = '{16'd40000, 16'd1000, 16'd35000, 16'd2000};
      init_thr[3] = '{16'd5000, 16'd200, 16'd4000, 16'd300};
      init_thr[4] = '{16'd6000, 16'd50, 16'd5000, 16'd100};
      for (int q = 0; q < 5; q++) begin
         bval[q] = '0;
         for (int k = 0; k < 4; k++) bthr[q][k] = '0;
      end

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 flags in reset", flags_now(), 32'h0);
      chk("R1 ready in reset", {31'h0, data_ready}, 32'h0);
      rst_n = 1'b1;

      // R2: limit writes and sample changes without a strobe
      for (int q = 0; q < 5; q++)
         for (int k = 0; k < 4; k++) wr_lim(q, k, init_thr[q][k]);
      bval[0] = 16'h7FFF; bval[1] = 16'hFFFF; bval[2] = 16'h0000;
      bval[3] = 16'hFFFF; bval[4] = 16'h0000;
      @(negedge clk); drive_vals();
      repeat (3) @(negedge clk);
      chk("R2 flags zero before first strobe", flags_now(), 32'h0);
      chk("R2 ready low before first strobe", {31'h0, data_ready}, 32'h0);

      set_mid();
      strobe_and_check("R2 first sample at mid values");
      chk("R2 ready after first strobe", {31'h0, data_ready}, 32'h1);

      // R3 R4 R8: sweep every limit at -1, 0, +1
      for (int k = 0; k < 4; k++)
         for (int d = -1; d <= 1; d++) begin
            for (int q = 0; q < 5; q++) bval[q] = bthr[q][k] + 16'(d);
            strobe_and_check($sformatf("R3 R4 R8 sweep limit %0d delta %0d", k, d));
         end

      // R5: signed vs unsigned corners
      begin
         logic [15:0] corners [6];
         corners = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'hF5FF};
         for (int c = 0; c < 6; c++) begin
            for (int q = 0; q < 5; q++) bval[q] = corners[c];
            strobe_and_check($sformatf("R5 corner %h", corners[c]));
         end
      end

      // R7: isolate each quantity's bit pair
      for (int q = 0; q < 5; q++) begin
         set_mid(); bval[q] = bthr[q][0] + 16'd1;
         strobe_and_check($sformatf("R7 upper pair of quantity %0d", q));
         set_mid(); bval[q] = bthr[q][1] - 16'd1;
         strobe_and_check($sformatf("R7 lower pair of quantity %0d", q));
      end
      chk("R7 byte B low bits zero", {24'h0, alarm_flags_b[5:0], warn_flags_b[5:0]} & 32'hFFF, 32'h0);

      // R9: no strobe means no change
      set_mid(); bval[2] = 16'd50000;
      strobe_and_check("R9 baseline");
      set_mid();
      @(negedge clk); drive_vals();
      repeat (3) @(negedge clk);
      chk("R9 sample change without strobe", flags_now(), last_exp);
      wr_lim(2, 0, 16'd60000);
      repeat (2) @(negedge clk);
      chk("R9 limit change without strobe", flags_now(), last_exp);
      bval[2] = 16'd50000;
      strobe_and_check("R9 new limit after strobe");

      // R6: writes beyond the bank are ignored
      for (int a = 40; a < 64; a++) wr_byte(6'(a), 8'hFF);
      for (int q = 0; q < 5; q++) bval[q] = bthr[q][3];
      strobe_and_check("R6 writes above bank ignored");
      // R6: byte order, change only the LSB of supply lower warning
      wr_byte(6'(8*1 + 2*3 + 1), 8'h00);
      bthr[1][3] = {bthr[1][3][15:8], 8'h00};
      bval[1] = bthr[1][3];
      strobe_and_check("R6 LSB at odd address");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule